// File: doc/BRIEF.md
# Limit-Register Interval Timer

This block is a memory-mapped interval timer driven by an external microsecond tick enable. Each tick the count field advances. When the count meets the programmed limit, the count starts again at 1 and a pending flag is latched. The flag drives the interrupt output and stays set until software acknowledges it. Software acknowledges the interrupt by reading the clearing limit register. A second limit address loads a new period without disturbing the count or the pending flag. Both the limit and the count sit left-aligned in the 32-bit word, starting at bit 10, so a period of P ticks is programmed as (P+1) << 10.

A design can place one instance as the shared system tick and one instance next to each processor as its profiling tick. The parameter `HAS_CTRL` picks the variant. With it set, the instance has a start/stop word. With it cleared, the word reads as reserved and the counter always runs.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count is 1, the limit is 0, the pending flag and `irq_out` are 0, `rdata` is 0 and the run bit reads 1.
- R2: While running, a tick that does not hit the limit advances the count by exactly 1. The count wraps in its `CNT_W`-bit field.
- R3: With a nonzero limit L, a tick that finds the count at L-1 reloads the count to 1 and sets the pending flag. A write of (P+1) << 10 therefore gives a flag every P ticks.
- R4: Without a tick, or while stopped, the count holds its value.
- R5: A limit of 0 never sets the pending flag. The counter then runs freely.
- R6: A read of word address 0 returns the pending flag in bit 31 and clears the flag on the same edge. A flag-setting tick in that same cycle wins over the clear.
- R7: A write to word address 0 loads the limit from bits [SHIFT+CNT_W-1:SHIFT], resets the count to 1 and clears the pending flag.
- R8: A write to word address 2 loads the limit only. The count and the pending flag are kept.
- R9: Read layout: bit 31 is the pending flag, bits [SHIFT+CNT_W-1:SHIFT] hold the value, and the low SHIFT bits are 0. Address 1 returns the count. Addresses 0 and 2 return the limit. Reads of addresses 1, 2 and 3 leave the flag unchanged.
- R10: Word address 3, bit 0, is the run bit. Writing 0 freezes the count and writing 1 resumes counting. The run bit reads back in bit 0.
- R11: `irq_out` equals the pending flag, so it stays high until a clearing read or a clearing write.
- R12: `rdata` is registered. It is updated on the edge that samples `rd_en` and it holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle microsecond tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address: 0 limit (clearing), 1 count, 2 limit (keeping), 3 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Pending timer interrupt |

## Verification
A table of periods is checked against tick counts that fall short of the limit, land exactly on it and run past it. This separates an off-by-one compare from a correct one, and a self-clearing flag from a latched one. Directed sequences then check the two limit addresses against each other: both load the limit, but only one resets the count and clears the flag. They also check a clearing read against reads of the other addresses. Further sequences stop and restart the counter, and run it with a zero limit to confirm that no interrupt is raised.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [1:0] {
    REG_LIM_CLR  = 2'd0,
    REG_COUNT    = 2'd1,
    REG_LIM_KEEP = 2'd2,
    REG_CTRL     = 2'd3
  } ivt_reg_e;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             lim_wr_clr,
  input  logic             lim_wr_keep,
  input  logic [CNT_W-1:0] lim_val,
  input  logic             ack_rd,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] limit_q,
  output logic             flag_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             step;
  logic             terminal;
  logic [CNT_W-1:0] limit_m1;

  assign limit_m1 = limit_q - ONE;
  assign step     = tick && run;
  assign terminal = step && (limit_q != '0) && (count_q == limit_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= ONE;
      limit_q <= '0;
      flag_q  <= 1'b0;
    end else if (lim_wr_clr) begin
      limit_q <= lim_val;
      count_q <= ONE;
      flag_q  <= 1'b0;
    end else begin
      if (lim_wr_keep) limit_q <= lim_val;
      if (terminal) begin
        count_q <= ONE;
        flag_q  <= 1'b1;
      end else begin
        if (step)   count_q <= count_q + ONE;
        if (ack_rd) flag_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ivt_run_ctrl.sv
module ivt_run_ctrl #(
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctrl_wr,
  input  logic        ctrl_bit,
  output logic        run,
  output logic [31:0] ctrl_word
);
  generate
    if (HAS_CTRL) begin : g_ctrl
      logic run_q;
      always_ff @(posedge clk) begin
        if (rst)          run_q <= 1'b1;
        else if (ctrl_wr) run_q <= ctrl_bit;
      end
      assign run       = run_q;
      assign ctrl_word = {31'd0, run_q};
    end else begin : g_free
      logic unused_in;
      assign unused_in = ctrl_wr ^ ctrl_bit ^ clk ^ rst;
      assign run       = 1'b1;
      assign ctrl_word = 32'd0;
    end
  endgenerate
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback
  import ivt_pkg::*;
#(
  parameter int CNT_W = 21,
  parameter int SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  ivt_reg_e         sel,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] limit,
  input  logic             flag,
  input  logic [31:0]      ctrl_word,
  output logic [31:0]      rdata_q
);
  function automatic logic [31:0] place(input logic [CNT_W-1:0] v, input logic f);
    logic [31:0] w;
    w = '0;
    w[SHIFT +: CNT_W] = v;
    w[31] = f;
    return w;
  endfunction

  logic [31:0] mux;
  always_comb begin
    unique case (sel)
      REG_COUNT: mux = place(count, flag);
      REG_CTRL:  mux = ctrl_word;
      default:   mux = place(limit, flag);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= mux;
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W    = 21,
  parameter int SHIFT    = 10,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_out
);
  localparam int FIELD_TOP = SHIFT + CNT_W - 1;

  ivt_reg_e         sel;
  logic             run;
  logic [31:0]      ctrl_word;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit_q;
  logic             flag_q;
  logic [CNT_W-1:0] lim_val;

  assign sel     = ivt_reg_e'(addr);
  assign lim_val = wdata[FIELD_TOP:SHIFT];
  assign irq_out = flag_q;

  ivt_run_ctrl #(.HAS_CTRL(HAS_CTRL)) u_run (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_en && sel == REG_CTRL),
    .ctrl_bit  (wdata[0]),
    .run       (run),
    .ctrl_word (ctrl_word)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick_en),
    .run         (run),
    .lim_wr_clr  (wr_en && sel == REG_LIM_CLR),
    .lim_wr_keep (wr_en && sel == REG_LIM_KEEP),
    .lim_val     (lim_val),
    .ack_rd      (rd_en && sel == REG_LIM_CLR),
    .count_q     (count_q),
    .limit_q     (limit_q),
    .flag_q      (flag_q)
  );

  ivt_readback #(.CNT_W(CNT_W), .SHIFT(SHIFT)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .sel       (sel),
    .count     (count_q),
    .limit     (limit_q),
    .flag      (flag_q),
    .ctrl_word (ctrl_word),
    .rdata_q   (rdata)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
  parameter int CNT_W = 21,
  parameter int SHIFT = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             irq_out,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] limit_q,
  input logic             run
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic wr_clr, wr_keep, wr_ctrl, rd_ack, hit;
  assign wr_clr  = wr_en && addr == 2'd0;
  assign wr_keep = wr_en && addr == 2'd2;
  assign wr_ctrl = wr_en && addr == 2'd3;
  assign rd_ack  = rd_en && addr == 2'd0;
  assign hit     = tick_en && run && limit_q != '0 && count_q == limit_q - ONE;

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick_en && run && !wr_clr && !hit) |=> count_q == $past(count_q) + ONE);

  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (hit && !wr_clr) |=> (count_q == ONE && irq_out));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    ((!tick_en || !run) && !wr_clr) |=> $stable(count_q));

  a_r5_no_fire: assert property (@(posedge clk) disable iff (rst)
    (limit_q == '0 && !irq_out) |=> !irq_out);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !hit) |=> !irq_out);

  a_r6_ack_reports: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> rdata[31] == $past(irq_out));

  a_r7_clear_write: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> (count_q == ONE && !irq_out && limit_q == $past(wdata[SHIFT +: CNT_W])));

  a_r8_keep_write: assert property (@(posedge clk) disable iff (rst)
    (wr_keep && !tick_en && !rd_ack) |=>
      (count_q == $past(count_q) && irq_out == $past(irq_out)
       && limit_q == $past(wdata[SHIFT +: CNT_W])));

  a_r10_run_bit: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> run == $past(wdata[0]));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W), .SHIFT(SHIFT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq_out (irq_out),
  .count_q (count_q),
  .limit_q (limit_q),
  .run     (run)
);

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ivt_timer u_ivt_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  // limit, ticks, expected count, expected irq
  localparam int unsigned VEC [8][4] = '{
    '{5, 3, 4, 0}, '{5, 4, 1, 1}, '{5, 6, 3, 1}, '{0, 7, 8, 0},
    '{2, 1, 1, 1}, '{2, 3, 1, 1}, '{10, 8, 9, 0}, '{10, 9, 1, 1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk) begin wr_en = 1'b1; addr = a; wdata = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk) begin rd_en = 1'b1; addr = a; end
    @(negedge clk) rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] word(input int unsigned v, input logic f);
    return {f, 31'(v << 10)};
  endfunction

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    check("R1 rdata after reset", rdata, 32'd0);
    bus_rd(2'd1, r); check("R1 R9 count after reset", r, word(1, 0));
    bus_rd(2'd0, r); check("R1 limit after reset", r, 32'd0);
    bus_rd(2'd3, r); check("R1 R10 run bit after reset", r, 32'd1);

    // table of periods
    for (int k = 0; k < 8; k++) begin
      bus_wr(2'd0, VEC[k][0] << 10);
      do_tick(int'(VEC[k][1]));
      bus_rd(2'd1, r);
      check("R2 R3 R5 table count", r, word(VEC[k][2], VEC[k][3][0]));
      check("R3 R11 table irq", {31'd0, irq_out}, VEC[k][3]);
    end

    // keep-alias versus clearing alias
    bus_wr(2'd0, 32'd3 << 10);
    do_tick(2);
    bus_rd(2'd1, r); check("R3 flag at limit", r, word(1, 1));
    do_tick(1);
    bus_wr(2'd2, 32'd6 << 10);
    bus_rd(2'd1, r); check("R8 keep write leaves count and flag", r, word(2, 1));
    bus_rd(2'd2, r); check("R9 keep address readback", r, word(6, 1));
    check("R9 non-clearing read keeps irq", {31'd0, irq_out}, 32'd1);
    bus_rd(2'd0, r); check("R6 clearing read returns flag", r, word(6, 1));
    check("R6 irq cleared by read", {31'd0, irq_out}, 32'd0);
    @(negedge clk); check("R12 rdata holds", rdata, word(6, 1));

    // stop and resume
    bus_wr(2'd3, 32'd0);
    do_tick(3);
    bus_rd(2'd1, r); check("R4 R10 stopped count holds", r, word(2, 0));
    bus_rd(2'd3, r); check("R10 run bit reads 0", r, 32'd0);
    bus_wr(2'd3, 32'd1);
    do_tick(1);
    bus_rd(2'd1, r); check("R10 R2 resumed count", r, word(3, 0));

    // clearing write
    do_tick(3);
    check("R11 irq held high", {31'd0, irq_out}, 32'd1);
    bus_wr(2'd0, 32'd4 << 10);
    check("R7 write clears irq", {31'd0, irq_out}, 32'd0);
    bus_rd(2'd1, r); check("R7 write resets count", r, word(1, 0));
    bus_rd(2'd0, r); check("R7 new limit", r, word(4, 0));

    // free run with zero limit
    bus_wr(2'd0, 32'd0);
    do_tick(20);
    check("R5 no irq with zero limit", {31'd0, irq_out}, 32'd0);
    bus_rd(2'd1, r); check("R5 free-running count", r, word(21, 0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule